// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address through a two-level table in memory, with 4 KB pages. The upper ten address bits pick a word in a page directory, the next ten pick a word in the page table that the directory word names, and the low twelve bits pass through unchanged as the page offset. Each table word carries a 20-bit frame number in its upper bits and protection attributes in its low bits. The walker checks these attributes against the kind of access and reports a fault when the access is not allowed. On a fault it also keeps the offending linear address in a dedicated register.

A requester presents one access at a time with a single-cycle `req_valid` pulse, along with a write flag and a user/supervisor flag, and then waits for `done`. The walker reads table words through a 32-bit read port that uses a request and response handshake. A small fully associative translation cache keeps recent successful translations. A lookup that hits the cache answers on the next cycle with no memory traffic. A `flush` input clears the cache.

Top module: `pgwalk`

## Requirements
- R1: While reset is active and right after it, `done`, `fault` and `mem_rd_en` are low and `fault_addr` reads zero.
- R2: On a cache miss, the first memory read goes to `{dir_base[31:12], lin[31:22], 2'b00}`, which is the directory base plus four times the directory index.
- R3: The second read goes to `{pde[31:12], lin[21:12], 2'b00}`, where `pde` is the directory word. `mem_rd_en` and `mem_rd_addr` stay steady until `mem_rd_valid` answers them.
- R4: A successful miss takes exactly two memory reads. It ends with a one-cycle `done` pulse, `fault` low and `phys_addr = {pte[31:12], lin[11:0]}`, where `pte` is the table word.
- R5: A word whose bit 0 (present) is 0 raises a fault. A non-present directory word faults after one read and never issues the table read.
- R6: A user access (`req_user`=1) faults if bit 2 (user-allowed) is 0 in the directory word or in the table word. A supervisor access ignores bit 2.
- R7: A user write faults if bit 1 (writable) is 0 in either word. A supervisor write ignores bit 1.
- R8: Every fault ends with `done` and `fault` high together and loads the request's linear address into `fault_addr`. `fault_addr` keeps its value through all accesses that do not fault.
- R9: A request whose page matches a cached translation sets `done` in the cycle after it is accepted and makes no memory read. It applies the R6 and R7 rules to the AND of the two levels' bits 1 and 2.
- R10: The cache holds 4 translations and fills its slots in round-robin order. Only walks that succeed are stored, so after four later installs a page must be walked again.
- R11: A `flush` pulse invalidates every cached translation, so the next access to any page takes two reads.
- R12: A `req_valid` pulse that arrives while a walk is in progress is ignored. It produces no second `done`, and its page is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request pulse, accepted when idle |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user access, 0 for supervisor |
| dir_base | input | 32 | Page directory base, bits 31:12 used |
| flush | input | 1 | Invalidate all cached translations |
| mem_rd_en | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 32 | Table word returned |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | High with `done` when the access faulted |
| phys_addr | output | 32 | Physical address, valid with `done` and no fault |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
The bench builds the block with the default cache depth of 4 entries. With that depth, it takes only a handful of installs to fill every slot and then evict the oldest one. The run places a directory and several table words in a small model memory. It then drives a fixed sequence of accesses that exercises both fault levels, both protection bits, hits that fault, the order in which entries are evicted, a flush, and a request sent while a walk is in progress.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int FRM_W  = ADDR_W - OFF_W;
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;

  typedef struct packed {
    logic [FRM_W-1:0] frame;
    logic             rw;
    logic             us;
  } xlat_t;

  function automatic logic denied(input logic rw, input logic us,
                                  input logic user, input logic write);
    return user && (!us || (write && !rw));
  endfunction
endpackage

// File: rtl/pgwalk_tlb.sv
module pgwalk_tlb
  import pgwalk_pkg::*;
#(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [FRM_W-1:0] lk_vpn,
  output logic             lk_hit,
  output xlat_t            lk_data,
  input  logic             wr_en,
  input  logic [FRM_W-1:0] wr_vpn,
  input  xlat_t            wr_data
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     hit_vec;
  xlat_t            sel_data [N];
  logic [PTR_W-1:0] ptr_q, ptr_n;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic             v_q;
    logic [FRM_W-1:0] vpn_q;
    xlat_t            d_q;
    logic             load;

    assign load        = wr_en && (ptr_q == PTR_W'(i));
    assign hit_vec[i]  = v_q && (vpn_q == lk_vpn);
    assign sel_data[i] = hit_vec[i] ? d_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        vpn_q <= '0;
        d_q   <= '0;
      end else begin
        if (flush) v_q <= 1'b0;
        if (load) begin
          v_q   <= 1'b1;
          vpn_q <= wr_vpn;
          d_q   <= wr_data;
        end
      end
    end
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < N; i++) lk_data = lk_data | sel_data[i];
    lk_hit = |hit_vec;
  end

  always_comb begin
    ptr_n = ptr_q;
    if (wr_en) ptr_n = (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  // R10: a page never occupies two slots
  p_hit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/pgwalk_walker.sv
module pgwalk_walker
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              tlb_hit,
  input  xlat_t             tlb_data,
  output logic              tlb_wr_en,
  output logic [FRM_W-1:0]  tlb_wr_vpn,
  output xlat_t             tlb_wr_data,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [ADDR_W-1:0] fault_addr
);
  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL} state_t;

  state_t            st_q, st_n;
  logic [ADDR_W-1:0] lin_q, lin_n;
  logic              wr_q, wr_n, user_q, user_n;
  logic [FRM_W-1:0]  pfrm_q, pfrm_n;
  logic              prw_q, prw_n, pus_q, pus_n;
  logic              done_q, done_n, fault_q, fault_n;
  logic [ADDR_W-1:0] phys_q, phys_n, faddr_q, faddr_n;
  logic              rw_c, us_c;
  logic              unused_bits;

  assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rd_data[OFF_W-1:BIT_US+1]};

  assign rw_c = prw_q & mem_rd_data[BIT_RW];
  assign us_c = pus_q & mem_rd_data[BIT_US];

  always_comb begin
    st_n = st_q; lin_n = lin_q; wr_n = wr_q; user_n = user_q;
    pfrm_n = pfrm_q; prw_n = prw_q; pus_n = pus_q;
    phys_n = phys_q; faddr_n = faddr_q;
    done_n = 1'b0; fault_n = 1'b0;
    tlb_wr_en = 1'b0;
    tlb_wr_data = '{frame: mem_rd_data[ADDR_W-1:OFF_W], rw: rw_c, us: us_c};
    case (st_q)
      S_IDLE: if (req_valid) begin
        if (tlb_hit) begin
          done_n = 1'b1;
          if (denied(tlb_data.rw, tlb_data.us, req_user, req_write)) begin
            fault_n = 1'b1;
            faddr_n = req_lin;
          end else begin
            phys_n = {tlb_data.frame, req_lin[OFF_W-1:0]};
          end
        end else begin
          st_n = S_DIR; lin_n = req_lin; wr_n = req_write; user_n = req_user;
        end
      end
      S_DIR: if (mem_rd_valid) begin
        if (!mem_rd_data[BIT_P] ||
            denied(mem_rd_data[BIT_RW], mem_rd_data[BIT_US], user_q, wr_q)) begin
          done_n = 1'b1; fault_n = 1'b1; faddr_n = lin_q; st_n = S_IDLE;
        end else begin
          pfrm_n = mem_rd_data[ADDR_W-1:OFF_W];
          prw_n  = mem_rd_data[BIT_RW];
          pus_n  = mem_rd_data[BIT_US];
          st_n   = S_TBL;
        end
      end
      S_TBL: if (mem_rd_valid) begin
        done_n = 1'b1; st_n = S_IDLE;
        if (!mem_rd_data[BIT_P] || denied(rw_c, us_c, user_q, wr_q)) begin
          fault_n = 1'b1; faddr_n = lin_q;
        end else begin
          phys_n    = {mem_rd_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
          tlb_wr_en = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; lin_q <= '0; wr_q <= 1'b0; user_q <= 1'b0;
      pfrm_q <= '0; prw_q <= 1'b0; pus_q <= 1'b0;
      done_q <= 1'b0; fault_q <= 1'b0; phys_q <= '0; faddr_q <= '0;
    end else begin
      st_q <= st_n; lin_q <= lin_n; wr_q <= wr_n; user_q <= user_n;
      pfrm_q <= pfrm_n; prw_q <= prw_n; pus_q <= pus_n;
      done_q <= done_n; fault_q <= fault_n; phys_q <= phys_n; faddr_q <= faddr_n;
    end
  end

  assign mem_rd_en   = (st_q != S_IDLE);
  assign mem_rd_addr = (st_q == S_DIR)
                     ? {dir_base[ADDR_W-1:OFF_W], lin_q[ADDR_W-1 -: IDX_W], 2'b00}
                     : {pfrm_q, lin_q[OFF_W +: IDX_W], 2'b00};
  assign tlb_wr_vpn  = lin_q[ADDR_W-1:OFF_W];
  assign done        = done_q;
  assign fault       = fault_q;
  assign phys_addr   = phys_q;
  assign fault_addr  = faddr_q;

  // R3: an outstanding read holds its address until answered
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
  // R4: no completion while the directory read is still outstanding
  p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DIR && !mem_rd_valid) |=> !done);
  // R8: the fault register moves only when a fault is reported
  p_faddr_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (fault && done));
  // R9: a cached page completes in the next cycle
  p_hit_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && req_valid && tlb_hit) |=> done);
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int TLB_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              flush,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [ADDR_W-1:0] fault_addr
);
  logic             tlb_hit, tlb_wr_en;
  xlat_t            tlb_data, tlb_wr_data;
  logic [FRM_W-1:0] tlb_wr_vpn;

  pgwalk_tlb #(.N(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(req_lin[ADDR_W-1:OFF_W]), .lk_hit(tlb_hit), .lk_data(tlb_data),
    .wr_en(tlb_wr_en), .wr_vpn(tlb_wr_vpn), .wr_data(tlb_wr_data)
  );

  pgwalk_walker u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_lin(req_lin), .req_write(req_write),
    .req_user(req_user), .dir_base(dir_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .tlb_hit(tlb_hit), .tlb_data(tlb_data),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_data(tlb_wr_data),
    .done(done), .fault(fault), .phys_addr(phys_addr), .fault_addr(fault_addr)
  );
endmodule

// File: tb/pgwalk_bench.sv
module pgwalk_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, req_valid, req_write, req_user, flush;
  logic [31:0] req_lin, dir_base, mem_rd_addr, mem_rd_data;
  logic        mem_rd_en, mem_rd_valid, done, fault;
  logic [31:0] phys_addr, fault_addr;

  logic [31:0] mem [4096];
  int          n_checks, n_errors, rd_cnt;
  logic [31:0] rd_a0, rd_a1;

  pgwalk u_pgwalk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
    .flush(flush), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .fault(fault), .phys_addr(phys_addr), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
    end else begin
      mem_rd_valid <= mem_rd_en && !mem_rd_valid;
      mem_rd_data  <= mem[mem_rd_addr[13:2]];
    end
  end

  always @(posedge clk) begin
    if (mem_rd_en && mem_rd_valid) begin
      if (rd_cnt == 0) rd_a0 = mem_rd_addr;
      else             rd_a1 = mem_rd_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  task automatic xlate(input logic [31:0] lin, input bit wr, input bit user,
                       input bit exp_f, input logic [31:0] exp_pa,
                       input int exp_rd, input string tag);
    int cyc;
    @(negedge clk);
    req_lin = lin; req_write = wr; req_user = user; req_valid = 1'b1;
    rd_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " fault"}, 32'(fault), 32'(exp_f));
    if (exp_f) chk({tag, " fault_addr"}, fault_addr, lin);
    else       chk({tag, " phys"}, phys_addr, exp_pa);
    chk({tag, " reads"}, 32'(rd_cnt), 32'(exp_rd));
    if (exp_rd == 0) chk({tag, " hit latency"}, 32'(cyc), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 fault", 32'(fault), 32'd0);
    chk("R1 rd_en", 32'(mem_rd_en), 32'd0);
    chk("R1 fault_addr", fault_addr, 32'd0);
  endtask

  task automatic t_walk();
    xlate(32'h0040_3ABC, 0, 1, 0, 32'h0ABC_DABC, 2, "R4 miss");
    chk("R2 dir addr", rd_a0, 32'h0000_1004);
    chk("R3 tbl addr", rd_a1, 32'h0000_200C);
    @(negedge clk);
    chk("R4 done pulse", 32'(done), 32'd0);
    xlate(32'h0040_3123, 0, 1, 0, 32'h0ABC_D123, 0, "R9 hit");
  endtask

  task automatic t_present();
    xlate(32'h0080_0000, 0, 0, 1, 0, 1, "R5 dir absent");
    xlate(32'h0040_4000, 0, 0, 1, 0, 2, "R5 tbl absent");
  endtask

  task automatic t_user();
    xlate(32'h0040_5010, 0, 1, 1, 0, 2, "R6 user on sup pte");
    xlate(32'h0040_5010, 0, 0, 0, 32'h0111_1010, 2, "R6 sup ok");
    xlate(32'h0040_5010, 0, 1, 1, 0, 0, "R9 R6 hit fault");
  endtask

  task automatic t_write();
    xlate(32'h0040_6004, 1, 1, 1, 0, 2, "R7 user write ro");
    xlate(32'h0040_6004, 0, 1, 0, 32'h0222_2004, 2, "R7 user read ok");
    xlate(32'h0040_6008, 1, 0, 0, 32'h0222_2008, 0, "R7 sup write hit");
    xlate(32'h0040_6004, 1, 1, 1, 0, 0, "R9 R7 hit fault");
  endtask

  task automatic t_dirlevel();
    xlate(32'h00C0_0000, 0, 1, 1, 0, 1, "R6 dir sup");
    xlate(32'h00C0_0000, 1, 0, 0, 32'h0333_3000, 2, "R7 sup write dir ro");
    chk("R8 fault_addr held", fault_addr, 32'h00C0_0000);
  endtask

  task automatic t_evict();
    xlate(32'h0040_7000, 0, 1, 0, 32'h0444_4000, 2, "R10 fifth install");
    xlate(32'h0040_3ABC, 0, 1, 0, 32'h0ABC_DABC, 2, "R10 oldest evicted");
    xlate(32'h0040_6004, 0, 1, 0, 32'h0222_2004, 0, "R10 kept entry");
    xlate(32'h0040_5010, 0, 0, 0, 32'h0111_1010, 2, "R10 second evicted");
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(32'h0040_7000, 0, 1, 0, 32'h0444_4000, 2, "R11 after flush");
  endtask

  task automatic t_busy();
    int cyc, extra;
    @(negedge clk);
    req_lin = 32'h0040_6ABC; req_write = 0; req_user = 1; req_valid = 1'b1;
    rd_cnt = 0;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    req_lin = 32'h00C0_0000; req_user = 0; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk("R12 first done", 32'(done), 32'd1);
    chk("R12 first phys", phys_addr, 32'h0222_2ABC);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R12 no second done", 32'(extra), 32'd0);
    xlate(32'h00C0_0010, 0, 0, 0, 32'h0333_3010, 2, "R12 ignored not cached");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_checks = 0; n_errors = 0; rd_cnt = 0; rd_a0 = '0; rd_a1 = '0;
    req_valid = 0; req_lin = '0; req_write = 0; req_user = 0; flush = 0;
    dir_base = 32'h0000_1000;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h401] = 32'h0000_2007;
    mem[12'h403] = 32'h0000_3001;
    mem[12'h803] = 32'h0ABC_D007;
    mem[12'h805] = 32'h0111_1003;
    mem[12'h806] = 32'h0222_2005;
    mem[12'h807] = 32'h0444_4007;
    mem[12'hC00] = 32'h0333_3007;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_present();
    t_user();
    t_write();
    t_dirlevel();
    t_evict();
    t_flush();
    t_busy();
    summary();
  end
endmodule